// File: doc/BRIEF.md
# Interrupt Recognition and Vectoring Unit

This unit sits beside a processor's execution sequencer. At every instruction boundary, or between whole element moves of a block-move instruction, it decides whether control must pass to an interrupt handler. If so, it produces the 8-bit interrupt type and the address of that type's entry in the vector table.

Three request sources feed it:
- An asynchronous non-maskable line. Its rising edges are filtered and latched.
- A level-sensitive maskable request. It is registered every clock and gated by the interrupt-enable flag that the unit owns.
- A software request that carries its own type.

A maskable interrupt runs a two-pulse acknowledge handshake. The type is read from the external device on the second pulse.

Every taken interrupt ends in a single-cycle save strobe. During that cycle the core pushes flags, code segment and instruction pointer, and fetches the handler pointer at `vec_addr`. The enable flag is cleared at entry, and its previous value is kept for the flags image.

Top module: `intr_vector_unit`

## Requirements
- R1: During and right after a synchronous, active-high reset, `inta`, `busy` and `save_stb` are 0, and `ie_flag` is 0.
- R2: A rising edge on `nmi_pin` that stays high for at least `NMI_MIN_HIGH` (default 2) clock edges is latched as pending. At the next boundary it is taken without acknowledge pulses. The cycle after that boundary shows `save_stb`=1, `irq_type`=2 and `vec_addr`=0x008.
- R3: An `nmi_pin` pulse shorter than `NMI_MIN_HIGH` clock edges is never taken.
- R4: A non-maskable level already high when reset is released causes no interrupt. Recognition starts `NMI_ARM_CYC` (default 2) cycles after reset, and it needs a fresh low-to-high transition. A level held high triggers exactly once.
- R5: When several requests are present at a boundary, the order is non-maskable first, then software, then maskable.
- R6: A maskable request is taken only if `intr_req` was high at the clock edge before the boundary edge and `ie_flag` is 1. Otherwise the boundary passes with `busy` staying 0.
- R7: A maskable take makes `inta` go 1, 0, 1 on the three cycles after the boundary. `ack_type` is captured on the second pulse. The next cycle has `save_stb`=1, `irq_type`=captured type and `vec_addr`=type*4, with `vec_addr` being 10 bits with the two low bits zero. `save_stb` lasts exactly one cycle.
- R8: Any take clears `ie_flag` and loads `saved_ie` with the value `ie_flag` held just before. Outside a take, `ie_wr` loads `ie_flag` from `ie_wdata`.
- R9: Several non-maskable edges that arrive before service starts are merged into one take. An edge that arrives after a non-maskable service has started causes a further take at a later boundary.
- R10: `boundary` is ignored while `busy` is 1. A boundary with nothing eligible leaves the unit idle.
- R11: A software request taken at a boundary uses `sw_type`, produces no `inta` pulse, and shows `save_stb` in the cycle after the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Asynchronous non-maskable request, rising-edge sensitive |
| intr_req | input | 1 | Maskable request level |
| sw_req | input | 1 | Software interrupt request at this boundary |
| sw_type | input | TYPE_W | Type for the software request |
| boundary | input | 1 | Instruction or block-element boundary strobe |
| ie_wr | input | 1 | Write strobe for the enable flag |
| ie_wdata | input | 1 | Value written to the enable flag |
| ack_type | input | TYPE_W | Type driven by the device during acknowledge |
| inta | output | 1 | Acknowledge strobe |
| busy | output | 1 | Interrupt entry in progress |
| save_stb | output | 1 | One-cycle strobe to save flags, code segment and instruction pointer |
| irq_type | output | TYPE_W | Type of the interrupt being entered |
| vec_addr | output | TYPE_W+2 | Vector table entry address (type times four) |
| ie_flag | output | 1 | Interrupt-enable flag |
| saved_ie | output | 1 | Enable flag value from before the last take |

## Verification
A pending latch that sets wrongly shows up as an extra type-2 entry at the next boundary the bench offers. A latch that clears wrongly shows up as a missing entry. In both cases the fault is visible within one cycle of that boundary. A fault in the maskable sample register or the enable gating shows up as `busy` rising, or failing to rise, one cycle after the boundary. A miscounted acknowledge sequencer shows up as the wrong `inta` pattern, or as a wrong `vec_addr` on the save cycle. The bench sweeps all 256 types through both the acknowledge path and the software path, so a single wrong address bit is caught.

// File: rtl/intr_vector_unit.sv
module intr_vector_unit #(
  parameter int TYPE_W       = 8,
  parameter int NMI_TYPE     = 2,
  parameter int NMI_MIN_HIGH = 2,
  parameter int NMI_ARM_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin,
  input  logic              intr_req,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              boundary,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  input  logic [TYPE_W-1:0] ack_type,
  output logic              inta,
  output logic              busy,
  output logic              save_stb,
  output logic [TYPE_W-1:0] irq_type,
  output logic [TYPE_W+1:0] vec_addr,
  output logic              ie_flag,
  output logic              saved_ie
);
  localparam int CNT_W = $clog2(NMI_MIN_HIGH + 1);
  localparam int ARM_W = $clog2(NMI_ARM_CYC + 1);
  localparam logic [CNT_W-1:0] HI_MAX  = CNT_W'(NMI_MIN_HIGH);
  localparam logic [ARM_W-1:0] ARM_MAX = ARM_W'(NMI_ARM_CYC);
  localparam logic [TYPE_W-1:0] NMI_T  = TYPE_W'(NMI_TYPE);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_VEC} state_t;

  state_t            state;
  logic [1:0]        ack_cnt;
  logic [TYPE_W-1:0] type_q;
  logic              s1, s2, s2_d;
  logic [ARM_W-1:0]  arm_cnt;
  logic [CNT_W-1:0]  hi_cnt, hi_nxt;
  logic              nmi_pend, intr_q;

  wire armed     = (arm_cnt == ARM_MAX);
  wire nmi_start = s2 & ~s2_d & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s2_d <= 1'b1;
      arm_cnt <= '0;
      hi_cnt <= '0;
      intr_q <= 1'b0;
    end else begin
      s1 <= nmi_pin; s2 <= s1; s2_d <= s2;
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
      hi_cnt <= hi_nxt;
      intr_q <= intr_req;
    end
  end

  always_comb begin
    hi_nxt = hi_cnt;
    if (!s2) hi_nxt = '0;
    else if (nmi_start || (hi_cnt != '0 && hi_cnt != HI_MAX)) hi_nxt = hi_cnt + 1'b1;
  end

  wire nmi_qual = s2 && (hi_nxt == HI_MAX) && (hi_cnt != HI_MAX);

  wire idle     = (state == S_IDLE);
  wire at_bnd   = idle & boundary;
  wire take_nmi = at_bnd & nmi_pend;
  wire take_sw  = at_bnd & ~nmi_pend & sw_req;
  wire take_int = at_bnd & ~nmi_pend & ~sw_req & intr_q & ie_flag;
  wire take_any = take_nmi | take_sw | take_int;

  always_ff @(posedge clk) begin
    if (rst) nmi_pend <= 1'b0;
    else if (nmi_qual) nmi_pend <= 1'b1;
    else if (take_nmi) nmi_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_flag <= 1'b0;
      saved_ie <= 1'b0;
    end else if (take_any) begin
      ie_flag <= 1'b0;
      saved_ie <= ie_flag;
    end else if (ie_wr) begin
      ie_flag <= ie_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ack_cnt <= '0;
      type_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          ack_cnt <= '0;
          if (take_nmi) begin
            type_q <= NMI_T;
            state <= S_VEC;
          end else if (take_sw) begin
            type_q <= sw_type;
            state <= S_VEC;
          end else if (take_int) begin
            state <= S_ACK;
          end
        end
        S_ACK: begin
          ack_cnt <= ack_cnt + 1'b1;
          if (ack_cnt == 2'd2) begin
            type_q <= ack_type;
            state <= S_VEC;
          end
        end
        S_VEC:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign inta     = (state == S_ACK) && (ack_cnt != 2'd1);
  assign busy     = ~idle;
  assign save_stb = (state == S_VEC);
  assign irq_type = type_q;
  assign vec_addr = {type_q, 2'b00};
endmodule

// File: rtl/intr_vector_unit_chk.sv
module intr_vector_unit_chk #(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              boundary,
  input logic              busy,
  input logic              inta,
  input logic              save_stb,
  input logic              nmi_pend,
  input logic              sw_req,
  input logic              intr_q,
  input logic              ie_flag,
  input logic              saved_ie,
  input logic [TYPE_W-1:0] irq_type,
  input logic [TYPE_W-1:0] ack_type
);
  p_nmi_first_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && boundary && nmi_pend) |=> (save_stb && irq_type == TYPE_W'(NMI_TYPE)));

  p_ie_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && boundary && (nmi_pend || sw_req || (intr_q && ie_flag)))
      |=> (!ie_flag && saved_ie == $past(ie_flag)));

  p_masked_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && boundary && !nmi_pend && !sw_req && !(intr_q && ie_flag)) |=> !busy);

  p_ack_gap_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(inta) && !save_stb) |=> inta);

  p_type_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (inta && !$past(inta) && $past(busy)) |=> (save_stb && irq_type == $past(ack_type)));

  p_one_save_r7: assert property (@(posedge clk) disable iff (rst)
    save_stb |=> !save_stb);
endmodule

bind intr_vector_unit intr_vector_unit_chk #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_chk (
  .clk(clk), .rst(rst), .boundary(boundary), .busy(busy), .inta(inta),
  .save_stb(save_stb), .nmi_pend(nmi_pend), .sw_req(sw_req), .intr_q(intr_q),
  .ie_flag(ie_flag), .saved_ie(saved_ie), .irq_type(irq_type), .ack_type(ack_type)
);

// File: tb/intr_vector_unit_tb.sv
module intr_vector_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_pin = 1'b0, intr_req = 1'b0, sw_req = 1'b0, boundary = 1'b0;
  logic ie_wr = 1'b0, ie_wdata = 1'b0;
  logic [7:0] sw_type = '0, ack_type = '0;
  logic inta, busy, save_stb, ie_flag, saved_ie;
  logic [7:0] irq_type;
  logic [9:0] vec_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intr_vector_unit u_dut (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .intr_req(intr_req), .sw_req(sw_req),
    .sw_type(sw_type), .boundary(boundary), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .ack_type(ack_type), .inta(inta), .busy(busy), .save_stb(save_stb),
    .irq_type(irq_type), .vec_addr(vec_addr), .ie_flag(ie_flag), .saved_ie(saved_ie)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic set_ie(input logic v);
    ie_wr = 1'b1; ie_wdata = v;
    @(negedge clk);
    ie_wr = 1'b0;
  endtask

  task automatic nmi_pulse(input int w);
    nmi_pin = 1'b1;
    step(w);
    nmi_pin = 1'b0;
  endtask

  task automatic expect_nmi(input string tag);
    chk({tag, " save"}, save_stb, 1);
    chk({tag, " type"}, irq_type, 8'd2);
    chk({tag, " vec"}, vec_addr, 10'h008);
    chk({tag, " inta"}, inta, 0);
    step(1);
  endtask

  initial begin
    step(3);
    chk("R1 inta", inta, 0);
    chk("R1 busy", busy, 0);
    chk("R1 save", save_stb, 0);
    chk("R1 ie", ie_flag, 0);
    rst = 1'b0;
    step(1);
    chk("R1 busy after release", busy, 0);
    step(4);

    // R6: masked request ignored
    intr_req = 1'b1;
    step(1);
    bnd();
    chk("R6 masked", busy, 0);
    step(1);
    chk("R6 masked later", busy, 0);

    // R7 and R8: acknowledge sweep over every type
    for (int t = 0; t < 256; t++) begin
      set_ie(1'b1);
      ack_type = 8'(t);
      bnd();
      chk("R7 first pulse", inta, 1);
      chk("R8 ie cleared", ie_flag, 0);
      chk("R8 saved", saved_ie, 1);
      step(1);
      chk("R7 gap", inta, 0);
      step(1);
      chk("R7 second pulse", inta, 1);
      step(1);
      chk("R7 save", save_stb, 1);
      chk("R7 type", irq_type, t);
      chk("R7 vec", vec_addr, t * 4);
      step(1);
      chk("R7 single save", save_stb, 0);
      chk("R7 idle", busy, 0);
    end

    // R6: request must be high in the cycle before the boundary
    intr_req = 1'b0;
    step(2);
    set_ie(1'b1);
    intr_req = 1'b1;
    bnd();
    chk("R6 late request", busy, 0);
    bnd();
    chk("R6 timely request", inta, 1);
    step(4);
    intr_req = 1'b0;
    chk("R8 write", ie_flag, 0);
    set_ie(1'b1);
    chk("R8 write one", ie_flag, 1);
    set_ie(1'b0);
    chk("R8 write zero", ie_flag, 0);

    // R11: software sweep
    for (int t = 0; t < 256; t++) begin
      sw_type = 8'(t);
      sw_req = 1'b1;
      bnd();
      sw_req = 1'b0;
      chk("R11 save", save_stb, 1);
      chk("R11 type", irq_type, t);
      chk("R11 vec", vec_addr, t * 4);
      chk("R11 no inta", inta, 0);
      step(1);
    end

    // R2 and R3: pulse width sweep
    for (int w = 1; w <= 4; w++) begin
      nmi_pulse(w);
      step(5);
      bnd();
      if (w >= 2) expect_nmi("R2 width");
      else begin
        chk("R3 short pulse", busy, 0);
        step(1);
      end
      step(1);
    end

    // R4: held level fires once
    nmi_pin = 1'b1;
    step(5);
    bnd();
    expect_nmi("R4 held first");
    step(1);
    bnd();
    chk("R4 held no repeat", busy, 0);
    nmi_pin = 1'b0;
    step(3);

    // R9: merge before service
    nmi_pulse(3);
    step(2);
    nmi_pulse(3);
    step(5);
    bnd();
    expect_nmi("R9 merged");
    bnd();
    chk("R9 merged once", busy, 0);
    step(1);

    // R9: re-arm after service start
    nmi_pulse(3);
    step(5);
    set_ie(1'b0);
    bnd();
    nmi_pulse(3);
    step(5);
    bnd();
    expect_nmi("R9 rearm");
    chk("R8 saved zero", saved_ie, 0);

    // R5: priority
    set_ie(1'b1);
    intr_req = 1'b1;
    sw_req = 1'b1;
    sw_type = 8'h55;
    nmi_pulse(3);
    step(5);
    bnd();
    expect_nmi("R5 nmi first");
    set_ie(1'b1);
    bnd();
    chk("R5 sw second", irq_type, 8'h55);
    chk("R5 sw save", save_stb, 1);
    step(1);
    sw_req = 1'b0;
    set_ie(1'b1);
    ack_type = 8'h21;
    bnd();
    chk("R5 intr last", inta, 1);

    // R10: boundary during acknowledge ignored
    boundary = 1'b1;
    sw_req = 1'b1;
    sw_type = 8'h77;
    @(negedge clk);
    boundary = 1'b0;
    sw_req = 1'b0;
    chk("R10 gap kept", inta, 0);
    step(1);
    chk("R10 second pulse", inta, 1);
    step(1);
    chk("R10 type", irq_type, 8'h21);
    step(1);
    chk("R10 idle", busy, 0);
    intr_req = 1'b0;
    step(1);
    bnd();
    chk("R10 nothing pending", busy, 0);

    // R4: level high across reset
    nmi_pin = 1'b1;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(8);
    bnd();
    chk("R4 no edge after reset", busy, 0);
    nmi_pin = 1'b0;
    step(4);
    nmi_pulse(2);
    step(5);
    bnd();
    expect_nmi("R4 fresh edge");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule